// File: doc/BRIEF.md
# PHY Analog Power Sequencer

This block brings the analog section of a storage-interface PHY up and down in a fixed order. It drives two control lines into the PHY: an active-low power-down line (`phy_pdb_o`, high means powered) and a DLL enable. It watches two status lines coming back from the PHY: calibration complete and DLL locked. Software or a higher-level controller pulses a power-on or power-off request. The sequencer then runs the whole sequence on its own. It shows `busy_o` while the sequence runs. At the end it reports either success on `done_o` or a coded failure on `err_o`.

Every sequence starts by pulling both control lines low, so that the PHY's calibration logic can initialise. A power-off ends there. A power-on then runs three timed stages:

1. A settle wait. Power-down-bar is then raised.
2. A calibration wait. Calibration-complete is then sampled. If it is set, the DLL enable is raised.
3. A lock wait. DLL-locked is then sampled.

Each wait is a microsecond figure multiplied by the clock frequency parameter in MHz. A check that fails aborts the sequence. The control lines are left where they stood, and the code on `err_o` names the stage that failed. Both status lines are asynchronous to the sequencer clock, so each passes through a two-flop synchroniser. The asynchronous reset is released through a reset synchroniser.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `phy_pdb_o`, `phy_dll_en_o`, `busy_o` and `done_o` are 0, and `err_o` is 0 (code 0 = no error).
- R2: An accepted request drives `phy_pdb_o` and `phy_dll_en_o` low on the clock edge that accepts it. On that same edge it sets `busy_o` and clears `done_o` and `err_o`.
- R3: A power-off request completes one cycle after acceptance, with `done_o`=1, `busy_o`=0, `err_o`=0, and both control lines low.
- R4: For power-on, `phy_pdb_o` rises on the edge that comes SETTLE_US×CLK_MHZ+1 cycles after the accepting edge.
- R5: Exactly CAL_US×CLK_MHZ cycles after `phy_pdb_o` rises, the synchronised calibration-complete is sampled. If it is 1, `phy_dll_en_o` rises on that edge.
- R6: If calibration-complete is 0 at that sample, the sequence ends with `err_o`=1 (calibration timeout) and `busy_o`=0. `phy_pdb_o` stays 1 and `phy_dll_en_o` stays 0.
- R7: Exactly LOCK_US×CLK_MHZ cycles after `phy_dll_en_o` rises, the synchronised DLL-locked is sampled. If it is 1, the sequence ends with `done_o`=1, `err_o`=0, `busy_o`=0, and both control lines high.
- R8: If DLL-locked is 0 at that sample, the sequence ends with `err_o`=2 (DLL timeout) and `busy_o`=0. Both control lines stay high.
- R9: Status inputs pass through two flops. A level that reaches the input pin before the edge two cycles ahead of the sample edge is seen. A level that arrives only before the edge one cycle ahead is not seen.
- R10: Requests that arrive while `busy_o` is 1 are ignored. The running sequence keeps its timing and its result.
- R11: When power-on and power-off are requested in the same cycle, power-off is performed.
- R12: `done_o` and `err_o` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on request, sampled when idle |
| pwr_off_req | input | 1 | Power-off request, sampled when idle; wins over power-on |
| cal_done_i | input | 1 | PHY calibration complete (asynchronous) |
| dll_rdy_i | input | 1 | PHY DLL locked (asynchronous) |
| phy_pdb_o | output | 1 | PHY power-down-bar, high = powered |
| phy_dll_en_o | output | 1 | PHY DLL enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence succeeded |
| err_o | output | 2 | Last failure: 0 none, 1 calibration timeout, 2 DLL timeout |

## Verification
All results count from the accepting edge E0. The low phase and busy are due after E0. Power-off completion is due after E1. The power-down-bar rise is due after E(S+1). The calibration verdict is due after E(S+C+1). The lock verdict is due after E(S+C+L+1), where S, C and L are the three stage lengths in cycles. Every task drives its inputs on the falling edge and then counts falling edges from E0. It checks each output one cycle before its due edge, to see that the output has not moved yet, and again right after the due edge. The synchroniser test raises calibration-complete two cycles ahead of the sample edge and then only one cycle ahead. This pins the two-flop latency down exactly.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOW    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_CAL    = 3'd3,
    ST_LOCK   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CAL  = 2'd1,
    ERR_DLL  = 2'd2
  } seq_err_e;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/seq_bit_sync.sv
module seq_bit_sync #(
  parameter int NBITS  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] d_i,
  output logic [NBITS-1:0] q_o
);

  genvar b;
  generate
    for (b = 0; b < NBITS; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end
      end
      assign q_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  assign expired_o = (cnt_q == limit_i - 1'b1);

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_we = 1'b1;
      cnt_d  = '0;
    end else if (en_i && !expired_o) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import phy_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 30,
  parameter int CAL_CYC    = 50,
  parameter int LOCK_CYC   = 110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic             cal_ok_i,
  input  logic             lock_ok_i,
  input  logic             tmr_exp_i,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic [CNT_W-1:0] tmr_limit_o,
  output logic             pdb_o,
  output logic             dll_en_o,
  output logic             busy_o,
  output logic             done_o,
  output seq_err_e         err_o
);

  seq_state_e state_q, state_d;
  logic       pdb_q, pdb_d;
  logic       dll_en_q, dll_en_d;
  logic       busy_q, busy_d;
  logic       done_q, done_d;
  seq_err_e   err_q, err_d;
  logic       is_on_q, is_on_d;
  logic       accept;

  assign accept = (state_q == ST_IDLE) && (on_req_i || off_req_i);

  always_comb begin
    unique case (state_q)
      ST_SETTLE: tmr_limit_o = CNT_W'(SETTLE_CYC);
      ST_CAL:    tmr_limit_o = CNT_W'(CAL_CYC);
      ST_LOCK:   tmr_limit_o = CNT_W'(LOCK_CYC);
      default:   tmr_limit_o = CNT_W'(SETTLE_CYC);
    endcase
  end

  assign tmr_en_o = (state_q == ST_SETTLE) || (state_q == ST_CAL) ||
                    (state_q == ST_LOCK);

  always_comb begin
    state_d   = state_q;
    pdb_d     = pdb_q;
    dll_en_d  = dll_en_q;
    busy_d    = busy_q;
    done_d    = done_q;
    err_d     = err_q;
    is_on_d   = is_on_q;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_LOW;
          pdb_d    = 1'b0;
          dll_en_d = 1'b0;
          busy_d   = 1'b1;
          done_d   = 1'b0;
          err_d    = ERR_NONE;
          is_on_d  = on_req_i && !off_req_i;
        end
      end
      ST_LOW: begin
        if (is_on_q) begin
          state_d   = ST_SETTLE;
          tmr_clr_o = 1'b1;
        end else begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_exp_i) begin
          state_d   = ST_CAL;
          pdb_d     = 1'b1;
          tmr_clr_o = 1'b1;
        end
      end
      ST_CAL: begin
        if (tmr_exp_i) begin
          if (cal_ok_i) begin
            state_d   = ST_LOCK;
            dll_en_d  = 1'b1;
            tmr_clr_o = 1'b1;
          end else begin
            state_d = ST_IDLE;
            busy_d  = 1'b0;
            err_d   = ERR_CAL;
          end
        end
      end
      ST_LOCK: begin
        if (tmr_exp_i) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          if (lock_ok_i) begin
            done_d = 1'b1;
          end else begin
            err_d = ERR_DLL;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        busy_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pdb_q    <= 1'b0;
      dll_en_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= ERR_NONE;
      is_on_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      pdb_q    <= pdb_d;
      dll_en_q <= dll_en_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
      err_q    <= err_d;
      is_on_q  <= is_on_d;
    end
  end

  assign pdb_o    = pdb_q;
  assign dll_en_o = dll_en_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R2
  accept_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!pdb_q && !dll_en_q && busy_q && !done_q && (err_q == ERR_NONE)));

  // R5
  dll_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_q) |-> $past(cal_ok_i));

  // R8
  dll_needs_pdb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_en_q |-> pdb_q);

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !accept) |=> done_q);

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q != ERR_NONE) && !accept) |=> $stable(err_q));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!done_q && (err_q == ERR_NONE)));

  // R6
  cal_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q == ERR_CAL) |-> (pdb_q && !dll_en_q && !busy_q));

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 10,
  parameter int SETTLE_US = 3,
  parameter int CAL_US    = 5,
  parameter int LOCK_US   = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       pwr_off_req,
  input  logic       cal_done_i,
  input  logic       dll_rdy_i,
  output logic       phy_pdb_o,
  output logic       phy_dll_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] err_o
);

  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int CAL_CYC    = CAL_US * CLK_MHZ;
  localparam int LOCK_CYC   = LOCK_US * CLK_MHZ;
  localparam int MAX_AB     = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC;
  localparam int MAX_CYC    = (MAX_AB > LOCK_CYC) ? MAX_AB : LOCK_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic             srst_n;
  logic [1:0]       stat_raw;
  logic [1:0]       stat_sync;
  logic             tmr_clr;
  logic             tmr_en;
  logic             tmr_exp;
  logic [CNT_W-1:0] tmr_limit;
  seq_err_e         err_e;

  seq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign stat_raw = {dll_rdy_i, cal_done_i};

  seq_bit_sync #(.NBITS(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   (stat_raw),
    .q_o   (stat_sync)
  );

  seq_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  seq_ctrl_fsm #(
    .CNT_W      (CNT_W),
    .SETTLE_CYC (SETTLE_CYC),
    .CAL_CYC    (CAL_CYC),
    .LOCK_CYC   (LOCK_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (srst_n),
    .on_req_i    (pwr_on_req),
    .off_req_i   (pwr_off_req),
    .cal_ok_i    (stat_sync[0]),
    .lock_ok_i   (stat_sync[1]),
    .tmr_exp_i   (tmr_exp),
    .tmr_clr_o   (tmr_clr),
    .tmr_en_o    (tmr_en),
    .tmr_limit_o (tmr_limit),
    .pdb_o       (phy_pdb_o),
    .dll_en_o    (phy_dll_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_e)
  );

  assign err_o = err_e;

endmodule

// File: tb/phy_pwr_seq_tb_top.sv
module phy_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 10;
  localparam int S_CYC      = 3 * MHZ;
  localparam int C_CYC      = 5 * MHZ;
  localparam int L_CYC      = 11 * MHZ;
  localparam int WDOG_MAX   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       on_req, off_req, cal_in, dll_in;
  logic       pdb, den, busy, done;
  logic [1:0] err;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_pwr_seq #(.CLK_MHZ(MHZ), .SETTLE_US(3), .CAL_US(5), .LOCK_US(11)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_on_req   (on_req),
    .pwr_off_req  (off_req),
    .cal_done_i   (cal_in),
    .dll_rdy_i    (dll_in),
    .phy_pdb_o    (pdb),
    .phy_dll_en_o (den),
    .busy_o       (busy),
    .done_o       (done),
    .err_o        (err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_MAX) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act cycles=%0d exp <=%0d", cyc, WDOG_MAX);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  // state vector {pdb, den, busy, done, err}
  task automatic check(string tag, logic [5:0] exp);
    logic [5:0] act;
    act = {pdb, den, busy, done, err};
    n_vec = n_vec + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%b exp=%b (pdb,den,busy,done,err)", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive request at a falling edge, leave just after the accepting edge E0
  task automatic pulse(logic on_v, logic off_v);
    on_req = on_v; off_req = off_v;
    @(negedge clk);
    on_req = 1'b0; off_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset state", 6'b000000);
  endtask

  task automatic t_off(logic was_on);
    pulse(1'b0, 1'b1);
    check("R2 off accepted low phase", 6'b001000);
    wait_n(1);
    check("R3 off complete", 6'b000100);
    wait_n(15);
    check("R12 done held", 6'b000100);
  endtask

  // full power-on; poke injects requests while busy
  task automatic t_on(logic cal_v, logic dll_v, logic poke);
    cal_in = cal_v; dll_in = dll_v;
    wait_n(3);
    pulse(1'b1, 1'b0);
    check("R2 on accepted low phase", 6'b001000);
    if (poke) begin
      on_req = 1'b1; off_req = 1'b1;
      wait_n(1);
      on_req = 1'b0; off_req = 1'b0;
      wait_n(S_CYC - 1);
    end else begin
      wait_n(S_CYC);
    end
    check(poke ? "R10 pdb timing kept while busy" : "R4 pdb still low", 6'b001000);
    wait_n(1);
    check("R4 pdb raised", 6'b101000);
    wait_n(C_CYC - 1);
    check("R5 dll enable not yet", 6'b101000);
    wait_n(1);
    if (!cal_v) begin
      check("R6 calibration timeout", 6'b100001);
      wait_n(20);
      check("R12 error held", 6'b100001);
      return;
    end
    check("R5 dll enable raised", 6'b111000);
    wait_n(L_CYC - 1);
    check("R7 lock not yet sampled", 6'b111000);
    wait_n(1);
    if (dll_v) begin
      check(poke ? "R10 result kept" : "R7 power-on success", 6'b110100);
    end else begin
      check("R8 DLL timeout", 6'b110010);
      wait_n(20);
      check("R12 error held", 6'b110010);
    end
  endtask

  task automatic t_both();
    pulse(1'b1, 1'b1);
    check("R11 both requests: low phase", 6'b001000);
    wait_n(1);
    check("R11 off performed", 6'b000100);
  endtask

  // late=0: cal arrives before edge two ahead of sample; late=1: one ahead
  task automatic t_sync(logic late);
    cal_in = 1'b0; dll_in = 1'b1;
    wait_n(3);
    pulse(1'b1, 1'b0);
    wait_n(S_CYC + C_CYC - 2 + (late ? 1 : 0));
    cal_in = 1'b1;
    wait_n(late ? 2 : 3);
    if (late) begin
      check("R9 late status not seen", 6'b100001);
    end else begin
      check("R9 status seen after two flops", 6'b111000);
      wait_n(L_CYC);
      check("R9 sequence completes", 6'b110100);
    end
  endtask

  initial begin
    rst_n = 1'b0; on_req = 1'b0; off_req = 1'b0; cal_in = 1'b0; dll_in = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_off(1'b0);
    t_on(1'b1, 1'b1, 1'b0);
    t_off(1'b1);
    t_on(1'b0, 1'b1, 1'b0);
    t_on(1'b1, 1'b0, 1'b0);
    t_on(1'b1, 1'b1, 1'b1);
    t_both();
    t_sync(1'b0);
    t_sync(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule